// File: doc/BRIEF.md
# ALU Stage with Operand Selection

This block is the arithmetic stage of a small 16-bit multi-cycle datapath. Two source multiplexers choose its operands, and a 4-bit operation code from the controller picks the function. The first operand is either the program counter or the first register read port. The second operand comes from one of four sources: the second register read port, a 6-bit immediate sign-extended, the same immediate zero-extended, or zero.

The stage has no clock and no state. It returns the 16-bit result and a match flag that tells the controller whether the two selected operands are equal. Branch decisions use this flag. Operation codes that have no function assigned fall back to addition, so an unused code never produces an undefined value.

Top module: `alu_stage`

## Requirements
- R1: When `sel_a` is 0 the first operand is `pc`. When `sel_a` is 1 it is `rd0`.
- R2: `sel_b` picks the second operand: 0 gives `rd1`, 1 gives `instr[5:0]` sign-extended to 16 bits, 2 gives `instr[5:0]` zero-extended, and 3 gives zero.
- R3: Operation code 0 adds the operands modulo 2^16. There is no carry output.
- R4: Operation code 1 gives first operand minus second operand, modulo 2^16.
- R5: Operation code 2 gives the bitwise AND of the operands. Code 3 gives the bitwise OR.
- R6: Operation code 8 shifts the first operand left by the value in the low 4 bits of the second operand. Vacated bits are filled with zero.
- R7: Operation code 9 shifts the first operand right logically by the value in the low 4 bits of the second operand. Vacated bits are filled with zero.
- R8: Operation codes 4 to 7 and 10 to 15 give the same result as addition.
- R9: `match` is 1 exactly when the two selected operands are equal, whatever the operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_a | input | 1 | First operand source select |
| sel_b | input | 2 | Second operand source select |
| op | input | 4 | Operation code |
| pc | input | 16 | Program counter value |
| rd0 | input | 16 | First register read port |
| rd1 | input | 16 | Second register read port |
| instr | input | 16 | Instruction word; the low 6 bits are the immediate |
| result | output | 16 | Operation result |
| match | output | 1 | Selected operands are equal |

## Verification
The hardest case to reach from the ports is a shift whose second operand has bits set above the low four. Only those four bits may count as the shift amount, so the stimulus must put both a large register value and a negative sign-extended immediate on the second operand while a shift code is applied.

Equality must also be shown to hold under every operation code. Random values almost never make two 16-bit operands equal, so the stimulus forces equality on purpose by copying one source into the other. It also covers a zero-extended immediate compared against a register that holds that same value.

// File: rtl/alu_stage.sv
module alu_stage #(
  parameter int DW   = 16,
  parameter int IMMW = 6
) (
  input  logic          sel_a,
  input  logic [1:0]    sel_b,
  input  logic [3:0]    op,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] rd0,
  input  logic [DW-1:0] rd1,
  input  logic [DW-1:0] instr,
  output logic [DW-1:0] result,
  output logic          match
);
  localparam int SHW = $clog2(DW);

  logic [IMMW-1:0] imm;
  logic [DW-1:0]   opa, opb;
  logic [SHW-1:0]  shamt;

  assign imm   = instr[IMMW-1:0];
  assign opa   = sel_a ? rd0 : pc;
  assign shamt = opb[SHW-1:0];
  assign match = (opa == opb);

  always_comb begin
    case (sel_b)
      2'd0:    opb = rd1;
      2'd1:    opb = {{(DW-IMMW){imm[IMMW-1]}}, imm};
      2'd2:    opb = {{(DW-IMMW){1'b0}}, imm};
      default: opb = '0;
    endcase
  end

  always_comb begin
    case (op)
      4'h1:    result = opa - opb;
      4'h2:    result = opa & opb;
      4'h3:    result = opa | opb;
      4'h8:    result = opa << shamt;
      4'h9:    result = opa >> shamt;
      default: result = opa + opb;
    endcase
  end
endmodule

module alu_stage_chk #(
  parameter int DW = 16
) (
  input logic          sel_a,
  input logic [1:0]    sel_b,
  input logic [3:0]    op,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] rd0,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [DW-1:0] result,
  input logic          match
);
  localparam int SHW = $clog2(DW);
  logic [DW-1:0] lo_mask, hi_mask;
  assign lo_mask = ~({DW{1'b1}} << opb[SHW-1:0]);
  assign hi_mask = ~({DW{1'b1}} >> opb[SHW-1:0]);

  always_comb begin
    if (!$isunknown({sel_a, sel_b, op, opa, opb, result, match})) begin
      // R1
      src_a_chk: assert (opa == (sel_a ? rd0 : pc));
      // R2
      zero_b_chk: assert (sel_b != 2'd3 || opb == '0);
      // R4
      sub_inverse_chk: assert (op != 4'h1 || DW'(result + opb) == opa);
      // R5
      and_subset_chk: assert (op != 4'h2 || ((result & ~opa) == '0 && (result & ~opb) == '0));
      // R5
      or_cover_chk: assert (op != 4'h3 || ((result & opa) == opa && (result & opb) == opb));
      // R6
      sll_fill_chk: assert (op != 4'h8 || (result & lo_mask) == '0);
      // R7
      srl_fill_chk: assert (op != 4'h9 || (result & hi_mask) == '0);
      // R8
      rsvd_add_chk: assert (!(op inside {[4'h4:4'h7], [4'hA:4'hF]}) || DW'(result - opb) == opa);
      // R9
      match_sub_chk: assert (op != 4'h1 || match == (result == '0));
    end
  end
endmodule

bind alu_stage alu_stage_chk #(.DW(DW)) u_chk (
  .sel_a(sel_a), .sel_b(sel_b), .op(op), .pc(pc), .rd0(rd0),
  .opa(opa), .opb(opb), .result(result), .match(match)
);

// File: tb/alu_stage_bench.sv
module alu_stage_bench;
  logic clk = 0, rst = 1;
  logic sel_a;
  logic [1:0] sel_b;
  logic [3:0] op;
  logic [15:0] pc, rd0, rd1, instr, result;
  logic match;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_stage u_alu_stage (.sel_a(sel_a), .sel_b(sel_b), .op(op), .pc(pc), .rd0(rd0),
    .rd1(rd1), .instr(instr), .result(result), .match(match));

  function automatic logic [15:0] m_b(input logic [1:0] s, input logic [15:0] r1, input logic [15:0] ir);
    case (s)
      2'd0: return r1;
      2'd1: return {{10{ir[5]}}, ir[5:0]};
      2'd2: return {10'd0, ir[5:0]};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] m_y(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b);
    case (o)
      4'h1: return a - b;
      4'h2: return a & b;
      4'h3: return a | b;
      4'h8: return a << b[3:0];
      4'h9: return a >> b[3:0];
      default: return a + b;
    endcase
  endfunction

  task automatic apply(input string tag, input logic sa, input logic [1:0] sb, input logic [3:0] o,
                       input logic [15:0] p, input logic [15:0] r0, input logic [15:0] r1,
                       input logic [15:0] ir);
    logic [15:0] a, b, ey;
    @(negedge clk);
    sel_a = sa; sel_b = sb; op = o; pc = p; rd0 = r0; rd1 = r1; instr = ir;
    #1;
    a = sa ? r0 : p;
    b = m_b(sb, r1, ir);
    ey = m_y(o, a, b);
    checks++;
    if (result !== ey) begin
      fails++;
      $display("FAIL %s result op=%h actual=%h expected=%h", tag, o, result, ey);
    end
    checks++;
    if (match !== (a == b)) begin
      fails++;
      $display("FAIL R9 match (%s) actual=%b expected=%b", tag, match, a == b);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    sel_a = 0; sel_b = 0; op = 0; pc = 0; rd0 = 0; rd1 = 0; instr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    checks++;
    if (result !== 16'd0 || match !== 1'b1) begin
      fails++;
      $display("FAIL R3 idle actual=%h/%b expected=0000/1", result, match);
    end
    apply("R1 pc", 0, 2'd3, 4'h0, 16'h1234, 16'h9999, 16'h0, 16'h0);
    apply("R1 rd0", 1, 2'd3, 4'h0, 16'h1234, 16'h9999, 16'h0, 16'h0);
    apply("R2 rd1", 1, 2'd0, 4'h0, 16'h0, 16'h0100, 16'h0023, 16'hFFFF);
    apply("R2 sext", 1, 2'd1, 4'h0, 16'h0, 16'h0100, 16'h0023, 16'hABE0);
    apply("R2 zext", 1, 2'd2, 4'h0, 16'h0, 16'h0100, 16'h0023, 16'hABE0);
    apply("R2 zero", 1, 2'd3, 4'h0, 16'h0, 16'h0100, 16'h0023, 16'hABFF);
    apply("R3 wrap", 1, 2'd0, 4'h0, 16'h0, 16'hFFFF, 16'h0001, 16'h0);
    apply("R4 wrap", 1, 2'd0, 4'h1, 16'h0, 16'h0000, 16'h0001, 16'h0);
    apply("R5 and", 1, 2'd0, 4'h2, 16'h0, 16'hF0F0, 16'h3C3C, 16'h0);
    apply("R5 or", 1, 2'd0, 4'h3, 16'h0, 16'hF0F0, 16'h3C3C, 16'h0);
    apply("R6 sll high bits", 1, 2'd0, 4'h8, 16'h0, 16'h8001, 16'hFFF3, 16'h0);
    apply("R6 sll sext", 0, 2'd1, 4'h8, 16'h00FF, 16'h0, 16'h0, 16'h0025);
    apply("R7 srl high bits", 1, 2'd0, 4'h9, 16'h0, 16'h8001, 16'h0011, 16'h0);
    apply("R7 srl 15", 1, 2'd0, 4'h9, 16'h0, 16'h8000, 16'h000F, 16'h0);
    for (int c = 4; c < 16; c++)
      if (c < 8 || c > 9) apply("R8 reserved", 1, 2'd0, 4'(c), 16'h0, 16'hFFF0, 16'h0021, 16'h0);
    for (int c = 0; c < 16; c++) apply("R9 equal", 1, 2'd0, 4'(c), 16'h0, 16'h5A5A, 16'h5A5A, 16'h0);
    apply("R9 zext equal", 1, 2'd2, 4'h3, 16'h0, 16'h003F, 16'h0, 16'h003F);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] r0v, r1v;
      r0v = 16'($urandom);
      r1v = ($urandom % 8 == 0) ? r0v : 16'($urandom);
      apply("R1-R9 random", 1'($urandom), 2'($urandom), 4'($urandom), 16'($urandom),
            r0v, r1v, 16'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule